// File: doc/BRIEF.md
# Card Status Change Event Registers

This block holds two 32-bit registers for a network function sitting on a card bus. The event register records that the Ethernet interrupt source or the wake source has fired. Each event bit is set by its source whatever the mask holds, and software clears it by writing one. The mask register gates the event bits onto two outputs: a level interrupt line and a status-change wake line. The interrupt line also needs an external interrupt-enable input.

A power-management PME status bit follows the wake event. Whenever the wake event sets, PME status sets as well. Clearing either one, through the event register or through the separate power-management write port, clears both. Both registers are reset only by a dedicated power-up reset. When a bus-mode input selects plain PCI operation, register accesses are ignored.

Top module: `cseRegTop`

## Requirements
- R1: After the power-up reset, both registers read 0, PME status is 0, and both the interrupt and wake outputs are 0.
- R2: The interrupt event bit sits at bit 15 of offset 0x30. It sets on any cycle in which intSrc is 1, whatever the mask holds.
- R3: Writing 1 to bit 15 of offset 0x30 clears the interrupt event only while intSrc is 0. Writing 0 to that bit leaves the event bit unchanged.
- R4: The wake event bit sits at bit 4 of offset 0x30. It sets, together with pmeStatus, on any cycle in which wakeSrc is 1, whatever the mask holds. Writing 1 to bit 4 clears both the wake event and pmeStatus; writing 0 changes neither.
- R5: A power-management write (pmeWrEn with pmeWrData = 1) clears both pmeStatus and the wake event bit. A power-management write with pmeWrData = 0 changes neither.
- R6: The mask register sits at offset 0x34 and has three fields: interrupt mask at bit 15, wake mask at bit 14, and a two-bit audio-enable field at bits 6:5. All other bits of both registers read 0. Bits 2 and 1 of the event register are excluded: see R12.
- R7: intOut is 1 exactly when the interrupt event bit, the interrupt mask bit and intEnable are all 1. A mask of 0 leaves the event register unchanged.
- R8: wakeOut is 1 exactly when the wake event bit and the wake mask bit are both 1.
- R9: While pciMode is 1, register writes have no effect and reads return 0.
- R10: If a set condition and a write-one clear reach the same event bit in the same cycle, the bit ends up set. The same holds for pmeStatus.
- R11: Read data appears on regRdData in the cycle after the read strobe. regRdData is 0 when no read is active or the offset is unmapped.
- R12: Bits 2 and 1 of the event register report, one clock late, the battery-voltage-detect ready input and the write-protect input respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| altRstN | input | 1 | Active-low power-up reset, asynchronous |
| pciMode | input | 1 | 1 selects plain PCI mode, which blocks register access |
| regAddr | input | 8 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Registered read data |
| pmeWrEn | input | 1 | Power-management status write strobe |
| pmeWrData | input | 1 | Value written to PME status (1 clears it) |
| intSrc | input | 1 | Ethernet interrupt source, level |
| wakeSrc | input | 1 | Ethernet wake source, level |
| intEnable | input | 1 | External interrupt enable |
| bvdReadyIn | input | 1 | Battery-voltage-detect ready status |
| bvdProtIn | input | 1 | Battery-voltage-detect write-protect status |
| intOut | output | 1 | Gated interrupt line |
| wakeOut | output | 1 | Gated status-change wake line |
| pmeStatus | output | 1 | PME status bit |

## Verification
The hardest cases to reach are collisions between a source and a clear. One is a write-one clear landing in the same cycle as an asserted source, which must leave the event bit set. The other is a clear attempted while the interrupt source is still high. The bench reaches both by holding intSrc or wakeSrc across the write strobe, and across the power-management write strobe, and then reading back after the source drops. The gating outputs are swept over every combination of mask bits, intEnable and event state. PCI-mode blocking is exercised by writing a pattern while pciMode is 1 and reading back after pciMode returns to 0.

// File: rtl/cse_pkg.sv
package cse_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int EVT_INT   = 15;
  localparam int EVT_WAKE  = 4;
  localparam int EVT_BRDY  = 2;
  localparam int EVT_BWP   = 1;
  localparam int MSK_INT   = 15;
  localparam int MSK_WAKE  = 14;
  localparam int MSK_AUD_LO = 5;
  localparam int AUD_W     = 2;

  typedef struct packed {
    logic wrEvt;
    logic wrMask;
    logic rdEvt;
    logic rdMask;
  } regStrb_t;
endpackage

// File: rtl/cseCtrl.sv
module cseCtrl
  import cse_pkg::*;
#(
  parameter logic [ADDR_W-1:0] EVT_OFS  = 8'h30,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h34
) (
  input  logic              pciMode,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output regStrb_t          strb
);
  logic accessOk;
  logic hitEvt;
  logic hitMask;

  always_comb begin
    accessOk    = !pciMode;
    hitEvt      = (regAddr == EVT_OFS);
    hitMask     = (regAddr == MASK_OFS);
    strb.wrEvt  = accessOk && regWrEn && hitEvt;
    strb.wrMask = accessOk && regWrEn && hitMask;
    strb.rdEvt  = accessOk && regRdEn && hitEvt;
    strb.rdMask = accessOk && regRdEn && hitMask;
  end
endmodule

// File: rtl/cseDatapath.sv
module cseDatapath
  import cse_pkg::*;
(
  input  logic              clk,
  input  logic              altRstN,
  input  regStrb_t          strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pmeWrEn,
  input  logic              pmeWrData,
  input  logic              intSrc,
  input  logic              wakeSrc,
  input  logic              intEnable,
  input  logic              bvdReadyIn,
  input  logic              bvdProtIn,
  output logic [DATA_W-1:0] rdData,
  output logic              intOut,
  output logic              wakeOut,
  output logic              pmeStatus
);
  logic             evtInt, evtWake, bvdRdy, bvdWp;
  logic             mskInt, mskWake;
  logic [AUD_W-1:0] audEn;
  logic             intClr, wakeClr;
  logic [DATA_W-1:0] evtWord, maskWord;

  always_comb begin
    intClr  = strb.wrEvt && wrData[EVT_INT] && !intSrc;
    wakeClr = (strb.wrEvt && wrData[EVT_WAKE]) || (pmeWrEn && pmeWrData);
    evtWord = '0;
    evtWord[EVT_INT]  = evtInt;
    evtWord[EVT_WAKE] = evtWake;
    evtWord[EVT_BRDY] = bvdRdy;
    evtWord[EVT_BWP]  = bvdWp;
    maskWord = '0;
    maskWord[MSK_INT]  = mskInt;
    maskWord[MSK_WAKE] = mskWake;
    maskWord[MSK_AUD_LO +: AUD_W] = audEn;
  end

  // event storage: a set beats a clear in the same cycle
  always_ff @(posedge clk or negedge altRstN) begin
    if (!altRstN) begin
      evtInt    <= 1'b0;
      evtWake   <= 1'b0;
      pmeStatus <= 1'b0;
      bvdRdy    <= 1'b0;
      bvdWp     <= 1'b0;
    end else begin
      evtInt    <= intSrc  || (evtInt && !intClr);
      evtWake   <= wakeSrc || (evtWake && !wakeClr);
      pmeStatus <= wakeSrc || (pmeStatus && !wakeClr);
      bvdRdy    <= bvdReadyIn;
      bvdWp     <= bvdProtIn;
    end
  end

  always_ff @(posedge clk or negedge altRstN) begin
    if (!altRstN) begin
      mskInt  <= 1'b0;
      mskWake <= 1'b0;
      audEn   <= '0;
    end else if (strb.wrMask) begin
      mskInt  <= wrData[MSK_INT];
      mskWake <= wrData[MSK_WAKE];
      audEn   <= wrData[MSK_AUD_LO +: AUD_W];
    end
  end

  always_ff @(posedge clk or negedge altRstN) begin
    if (!altRstN)         rdData <= '0;
    else if (strb.rdEvt)  rdData <= evtWord;
    else if (strb.rdMask) rdData <= maskWord;
    else                  rdData <= '0;
  end

  assign intOut  = evtInt && mskInt && intEnable;
  assign wakeOut = evtWake && mskWake;

  // R2
  int_set_chk: assert property (@(posedge clk) disable iff (!altRstN)
    intSrc |=> evtInt);
  // R3
  int_clear_chk: assert property (@(posedge clk) disable iff (!altRstN)
    (strb.wrEvt && wrData[EVT_INT] && !intSrc) |=> !evtInt);
  // R4
  wake_pme_set_chk: assert property (@(posedge clk) disable iff (!altRstN)
    wakeSrc |=> (evtWake && pmeStatus));
  // R5
  pme_clear_chk: assert property (@(posedge clk) disable iff (!altRstN)
    (pmeWrEn && pmeWrData && !wakeSrc) |=> (!evtWake && !pmeStatus));
  // R7
  mask_no_evt_chk: assert property (@(posedge clk) disable iff (!altRstN)
    (strb.wrMask && !intSrc && !strb.wrEvt) |=> $stable(evtInt));
  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (!altRstN)
    !(strb.rdEvt || strb.rdMask) |=> (rdData == '0));
endmodule

// File: rtl/cseRegTop.sv
module cseRegTop
  import cse_pkg::*;
(
  input  logic              clk,
  input  logic              altRstN,
  input  logic              pciMode,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              pmeWrEn,
  input  logic              pmeWrData,
  input  logic              intSrc,
  input  logic              wakeSrc,
  input  logic              intEnable,
  input  logic              bvdReadyIn,
  input  logic              bvdProtIn,
  output logic              intOut,
  output logic              wakeOut,
  output logic              pmeStatus
);
  regStrb_t strb;

  cseCtrl u_ctrl (
    .pciMode (pciMode),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .strb    (strb)
  );

  cseDatapath u_dp (
    .clk        (clk),
    .altRstN    (altRstN),
    .strb       (strb),
    .wrData     (regWrData),
    .pmeWrEn    (pmeWrEn),
    .pmeWrData  (pmeWrData),
    .intSrc     (intSrc),
    .wakeSrc    (wakeSrc),
    .intEnable  (intEnable),
    .bvdReadyIn (bvdReadyIn),
    .bvdProtIn  (bvdProtIn),
    .rdData     (regRdData),
    .intOut     (intOut),
    .wakeOut    (wakeOut),
    .pmeStatus  (pmeStatus)
  );

  // R9
  pci_rd_zero_chk: assert property (@(posedge clk) disable iff (!altRstN)
    pciMode |=> (regRdData == '0));
  // R9
  pci_wr_block_chk: assert property (@(posedge clk) disable iff (!altRstN)
    (pciMode && !intSrc && !wakeSrc && !pmeWrEn) |=> ($stable(intOut) && $stable(pmeStatus)));
endmodule

// File: tb/sim_cseRegTop.sv
module sim_cseRegTop;
  logic        clk = 1'b0;
  logic        altRstN = 1'b0;
  logic        pciMode = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        pmeWrEn = 1'b0, pmeWrData = 1'b0;
  logic        intSrc = 1'b0, wakeSrc = 1'b0, intEnable = 1'b0;
  logic        bvdReadyIn = 1'b0, bvdProtIn = 1'b0;
  logic        intOut, wakeOut, pmeStatus;
  int checks = 0, failures = 0;
  logic [31:0] rv;
  bit done = 0;

  always #10 clk = ~clk;

  cseRegTop u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    regAddr = a; regRdEn = 1'b1;
    @(posedge clk); @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 intOut", {31'b0, intOut}, 0);
    chk("R1 wakeOut", {31'b0, wakeOut}, 0);
    chk("R1 pme", {31'b0, pmeStatus}, 0);
    altRstN = 1'b1;
    @(negedge clk);
    rdReg(8'h30, rv); chk("R1 evt", rv, 0);
    rdReg(8'h34, rv); chk("R1 mask", rv, 0);

    // R11 no read -> zero; unmapped offset -> zero
    chk("R11 idle", regRdData, 0);
    wrReg(8'h34, 32'hFFFF_FFFF);
    rdReg(8'h38, rv); chk("R11 unmapped", rv, 0);

    // R6 mask fields, reserved bits zero
    rdReg(8'h34, rv); chk("R6 mask all", rv, 32'h0000_C060);
    wrReg(8'h34, 32'h0000_0040);
    rdReg(8'h34, rv); chk("R6 aud", rv, 32'h0000_0040);
    wrReg(8'h34, 32'h0000_0000);

    // R2 set regardless of mask (mask 0); R7 mask 0 leaves event
    intSrc = 1'b1; tick(); intSrc = 1'b0;
    rdReg(8'h30, rv); chk("R2 int set", rv, 32'h0000_8000);
    chk("R7 masked out", {31'b0, intOut}, 0);

    // R3 write 0 no effect
    wrReg(8'h30, 32'h0000_0000);
    rdReg(8'h30, rv); chk("R3 w0", rv, 32'h0000_8000);
    // R3 clear blocked while source asserted (also R10)
    intSrc = 1'b1;
    wrReg(8'h30, 32'h0000_8000);
    intSrc = 1'b0;
    rdReg(8'h30, rv); chk("R3 R10 busy", rv, 32'h0000_8000);
    wrReg(8'h30, 32'h0000_8000);
    rdReg(8'h30, rv); chk("R3 cleared", rv, 0);

    // R4 wake sets event and PME
    wakeSrc = 1'b1; tick(); wakeSrc = 1'b0;
    rdReg(8'h30, rv); chk("R4 wake set", rv, 32'h0000_0010);
    chk("R4 pme set", {31'b0, pmeStatus}, 1);
    wrReg(8'h30, 32'h0000_0000);
    chk("R4 w0 pme", {31'b0, pmeStatus}, 1);
    rdReg(8'h30, rv); chk("R4 w0", rv, 32'h0000_0010);
    wrReg(8'h30, 32'h0000_0010);
    rdReg(8'h30, rv); chk("R4 clear", rv, 0);
    chk("R4 pme clear", {31'b0, pmeStatus}, 0);

    // R5 PME write
    wakeSrc = 1'b1; tick(); wakeSrc = 1'b0;
    pmeWrEn = 1'b1; pmeWrData = 1'b0; tick(); pmeWrEn = 1'b0;
    chk("R5 pme w0", {31'b0, pmeStatus}, 1);
    pmeWrEn = 1'b1; pmeWrData = 1'b1; wakeSrc = 1'b1; tick();
    chk("R5 R10 pme set wins", {31'b0, pmeStatus}, 1);
    wakeSrc = 1'b0; tick(); pmeWrEn = 1'b0;
    chk("R5 pme clear", {31'b0, pmeStatus}, 0);
    rdReg(8'h30, rv); chk("R5 wake clear", rv, 0);

    // R10 wake W1C collision
    wakeSrc = 1'b1; wrReg(8'h30, 32'h0000_0010); wakeSrc = 1'b0;
    rdReg(8'h30, rv); chk("R10 wake", rv, 32'h0000_0010);
    wrReg(8'h30, 32'h0000_0010);

    // R7 R8 exhaustive gating sweep
    for (int e = 0; e < 4; e++) begin
      if (e[0]) begin intSrc = 1'b1; tick(); intSrc = 1'b0; end
      if (e[1]) begin wakeSrc = 1'b1; tick(); wakeSrc = 1'b0; end
      for (int m = 0; m < 4; m++) begin
        for (int en = 0; en < 2; en++) begin
          wrReg(8'h34, {16'b0, m[1], m[0], 14'b0});
          intEnable = en[0];
          #1;
          chk("R7 intOut", {31'b0, intOut}, {31'b0, e[0] & m[1] & en[0]});
          chk("R8 wakeOut", {31'b0, wakeOut}, {31'b0, e[1] & m[0]});
        end
      end
      wrReg(8'h30, 32'h0000_8010);
    end
    intEnable = 1'b0;

    // R9 PCI mode blocks
    wrReg(8'h34, 32'h0000_8000);
    pciMode = 1'b1;
    rdReg(8'h34, rv); chk("R9 rd zero", rv, 0);
    wrReg(8'h34, 32'h0000_4060);
    intSrc = 1'b1; tick(); intSrc = 1'b0;
    wrReg(8'h30, 32'h0000_8000);
    pciMode = 1'b0;
    rdReg(8'h34, rv); chk("R9 wr blocked mask", rv, 32'h0000_8000);
    rdReg(8'h30, rv); chk("R9 wr blocked evt", rv, 32'h0000_8000);
    wrReg(8'h30, 32'h0000_8000);

    // R12 battery-voltage status bits
    bvdReadyIn = 1'b1; tick();
    rdReg(8'h30, rv); chk("R12 ready", rv, 32'h0000_0004);
    bvdReadyIn = 1'b0; bvdProtIn = 1'b1; tick();
    rdReg(8'h30, rv); chk("R12 wp", rv, 32'h0000_0002);
    bvdProtIn = 1'b0;

    // R1 reset again clears everything
    intSrc = 1'b1; tick(); intSrc = 1'b0;
    altRstN = 1'b0; #1;
    chk("R1 reset pme", {31'b0, pmeStatus}, 0);
    @(negedge clk); altRstN = 1'b1; @(negedge clk);
    rdReg(8'h30, rv); chk("R1 reset evt", rv, 0);
    rdReg(8'h34, rv); chk("R1 reset mask", rv, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule